// File: doc/BRIEF.md
# Multi-queue request ring reader

This block takes one request entry from a set of request rings that live in host memory and hands it to the rest of the card. The request area starts with a single express slot. After it come several rings of equal size, back to back. Each ring is led by a four-byte header that holds its load pointer and its unload pointer. A command names a queue number, the entry size in bytes, the ring depth in entries and the base address of the request area. The block then works out where that ring's header sits, fetches both pointers and stops with an empty status when they match. Otherwise it fetches the entry the unload pointer selects, advances the pointer with wraparound and writes the new value back. An express command instead fetches the entry stored at the base address and leaves every pointer alone.

Memory is reached through a byte-wide master port. A request stays up until the memory acknowledges it. The entry fields, the pointer values and the outcome flags stay on the outputs until the next command is accepted.

The sequencer is built around the states IDLE, HDR, TEST, ENT, WRAP, WB and DONE, with these transitions:

- IDLE to HDR on a queue command, or IDLE to ENT on an express command.
- HDR to TEST after the fourth header byte is acknowledged.
- TEST to DONE when the two pointers are equal, and TEST to ENT when they differ.
- ENT to DONE after the last entry byte when the command is express or the depth is zero, and ENT to WRAP otherwise.
- WRAP stays in WRAP for as long as the advanced pointer is not below the ring span, then moves to WB.
- WB to DONE after the second pointer byte is written.
- DONE to IDLE always.

Top module: `ring_req_reader`

## Requirements
- R1: For a queue command, the first memory read goes to the header address: base + entry size + queue × (4 + entry size × depth).
- R2: The header holds two little-endian 16-bit pointers. The load pointer is at header+0 and header+1. The unload pointer is at header+2 and header+3. After a queue command, ptr_load shows the load pointer as read. ptr_unload shows the unload pointer as it now stands in memory.
- R3: When the load pointer equals the unload pointer, the command ends with empty=1 and ent_valid=0. It makes exactly the four header reads and no writes.
- R4: A non-empty queue's entry is read from header + 4 + unload pointer, one byte at a time, for entry-size bytes. The fields are: ent_count = little-endian bytes 0 and 1, ent_subdev = byte 2, ent_opcode = byte 3, ent_addr = little-endian bytes 4 to 7, and byte 8+k on ent_app[8k+7:8k]. Application bytes at or beyond the entry size read as zero. The entry size must lie between 8 and 16.
- R5: With a non-zero depth, the unload pointer becomes (unload + entry size) mod (entry size × depth). The modulo is exact even when the old pointer lies beyond the ring. The new value is written low byte first to header+2 and header+3.
- R6: With a depth of zero, the entry is still returned but nothing is written and the unload pointer is unchanged.
- R7: An express command reads entry-size bytes starting at the base address. It makes no header access and no write, and it returns ent_valid=1 and empty=0.
- R8: done is a single-cycle pulse that ends every command. In that cycle exactly one of ent_valid and empty is set. Both flags are cleared when a command is accepted and otherwise hold while idle.
- R9: A command is accepted only while busy is low. cmd_valid raised while busy is ignored and yields no further done pulse.
- R10: A memory request holds its address, direction and write data until mem_ack. No request is made while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, accepted when idle |
| cmd_express | input | 1 | 1 selects the express slot, 0 a numbered queue |
| cmd_queue | input | QW | Queue number |
| cmd_esize | input | EW | Entry size in bytes (8 to 16) |
| cmd_depth | input | DW | Ring depth in entries |
| cmd_base | input | AW | Request area base address |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| ent_valid | output | 1 | An entry was fetched |
| empty | output | 1 | The queue was found empty |
| ent_count | output | 16 | Entry byte count field |
| ent_subdev | output | 8 | Entry subdevice field |
| ent_opcode | output | 8 | Entry opcode field |
| ent_addr | output | 32 | Entry address field |
| ent_app | output | 64 | Application bytes, byte k at bits 8k+7:8k |
| ptr_load | output | 16 | Load pointer seen by the last queue command |
| ptr_unload | output | 16 | Unload pointer as left by the last queue command |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 8 | Read data |

## Verification
The assertions watch the following on every cycle:

- the single-cycle done pulse and its one-of-two outcome;
- that the flags hold while the block is idle;
- that requests keep their address and direction until acknowledged;
- that no request appears while idle;
- that no write happens once an empty or valid outcome is posted.

Only the bench scenarios can show the rest:

- that the header address follows the queue formula;
- that the fields are assembled from the right bytes;
- that the advanced pointer wraps to the correct value and lands in memory;
- that a zero depth or an express command leaves memory untouched.

These scenarios sweep queue number, entry size, depth, pointer position and memory latency.

// File: rtl/ring_rd_pkg.sv
package ring_rd_pkg;
    localparam int PTR_W    = 16;
    localparam int NXT_W    = PTR_W + 1;
    localparam int HDR_SIZE = 4;
    localparam int SLOT_MAX = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_TEST,
        ST_ENT,
        ST_WRAP,
        ST_WB,
        ST_DONE
    } rd_state_t;
endpackage

// File: rtl/ring_addr_calc.sv
module ring_addr_calc #(
    parameter int AW = 32,
    parameter int QW = 4,
    parameter int DW = 8,
    parameter int EW = 5
) (
    input  logic [AW-1:0]    base,
    input  logic [QW-1:0]    queue,
    input  logic [EW-1:0]    esize,
    input  logic [DW-1:0]    depth,
    output logic [AW-1:0]    hdr_addr,
    output logic [EW+DW-1:0] span
);
    localparam int SPAN_W   = EW + DW;
    localparam int STRIDE_W = SPAN_W + 1;
    localparam int HOFF_W   = STRIDE_W + QW;

    logic [STRIDE_W-1:0] stride;
    logic [HOFF_W-1:0]   hoff;

    always_comb begin
        // ring body size, then one header plus body per preceding queue
        span     = SPAN_W'(esize) * SPAN_W'(depth);
        stride   = STRIDE_W'(span) + STRIDE_W'(ring_rd_pkg::HDR_SIZE);
        hoff     = HOFF_W'(queue) * HOFF_W'(stride);
        hdr_addr = base + AW'(esize) + AW'(hoff);
    end
endmodule

// File: rtl/ring_wrap_step.sv
module ring_wrap_step #(
    parameter int SPAN_W = 13,
    parameter int NW     = 17
) (
    input  logic [NW-1:0]     cur,
    input  logic [SPAN_W-1:0] span,
    output logic              ge,
    output logic [NW-1:0]     reduced
);
    always_comb begin
        ge      = (span != '0) && (cur >= NW'(span));
        reduced = cur - NW'(span);
    end
endmodule

// File: rtl/ring_entry_store.sv
module ring_entry_store (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        cap,
    input  logic [3:0]  cap_idx,
    input  logic [7:0]  cap_byte,
    output logic [15:0] ent_count,
    output logic [7:0]  ent_subdev,
    output logic [7:0]  ent_opcode,
    output logic [31:0] ent_addr,
    output logic [63:0] ent_app
);
    localparam int NB = ring_rd_pkg::SLOT_MAX;

    logic [7:0] slot_b [NB];

    for (genvar g = 0; g < NB; g++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot_b[g] <= '0;
            else if (clr)
                slot_b[g] <= '0;
            else if (cap && cap_idx == 4'(g))
                slot_b[g] <= cap_byte;
        end
    end

    for (genvar k = 0; k < 8; k++) begin : g_app
        assign ent_app[8*k +: 8] = slot_b[8 + k];
    end

    assign ent_count  = {slot_b[1], slot_b[0]};
    assign ent_subdev = slot_b[2];
    assign ent_opcode = slot_b[3];
    assign ent_addr   = {slot_b[7], slot_b[6], slot_b[5], slot_b[4]};
endmodule

// File: rtl/ring_seq_fsm.sv
module ring_seq_fsm
    import ring_rd_pkg::*;
#(
    parameter int AW = 32,
    parameter int QW = 4,
    parameter int DW = 8,
    parameter int EW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_express,
    input  logic [QW-1:0]     cmd_queue,
    input  logic [EW-1:0]     cmd_esize,
    input  logic [DW-1:0]     cmd_depth,
    input  logic [AW-1:0]     cmd_base,
    output logic [QW-1:0]     lat_queue,
    output logic [EW-1:0]     lat_esize,
    output logic [DW-1:0]     lat_depth,
    output logic [AW-1:0]     lat_base,
    input  logic [AW-1:0]     hdr_addr,
    input  logic [EW+DW-1:0]  span,
    output logic [NXT_W-1:0]  wrap_cur,
    input  logic              wrap_ge,
    input  logic [NXT_W-1:0]  wrap_red,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ack,
    input  logic [7:0]        mem_rdata,
    output logic              ent_clr,
    output logic              ent_cap,
    output logic [3:0]        ent_idx,
    output logic              busy,
    output logic              done,
    output logic              ent_valid,
    output logic              empty,
    output logic [PTR_W-1:0]  ptr_load,
    output logic [PTR_W-1:0]  ptr_unload
);
    rd_state_t        state, nstate;
    logic [4:0]       idx;
    logic [4:0]       last_idx;
    logic [PTR_W-1:0] ld_r, ul_r;
    logic [NXT_W-1:0] nxt_r;
    logic [AW-1:0]    ent_base;
    logic             express_r;

    assign last_idx = lat_esize[4:0] - 5'd1;
    assign wrap_cur = nxt_r;

    // next-state decision
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE: if (cmd_valid) nstate = cmd_express ? ST_ENT : ST_HDR;
            ST_HDR:  if (mem_ack && idx == 5'd3) nstate = ST_TEST;
            ST_TEST: nstate = (ld_r == ul_r) ? ST_DONE : ST_ENT;
            ST_ENT:  if (mem_ack && idx == last_idx)
                         nstate = (express_r || span == '0) ? ST_DONE : ST_WRAP;
            ST_WRAP: if (!wrap_ge) nstate = ST_WB;
            ST_WB:   if (mem_ack && idx == 5'd1) nstate = ST_DONE;
            ST_DONE: nstate = ST_IDLE;
            default: nstate = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // port-side outputs decoded from the state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = idx[0] ? nxt_r[15:8] : nxt_r[7:0];
        unique case (state)
            ST_HDR: begin
                mem_req  = 1'b1;
                mem_addr = hdr_addr + AW'(idx);
            end
            ST_ENT: begin
                mem_req  = 1'b1;
                mem_addr = ent_base + AW'(idx);
            end
            ST_WB: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = hdr_addr + AW'(2) + AW'(idx);
            end
            default: ;
        endcase
        busy    = (state != ST_IDLE);
        done    = (state == ST_DONE);
        ent_clr = (state == ST_IDLE) && cmd_valid;
        ent_cap = (state == ST_ENT) && mem_ack;
        ent_idx = idx[3:0];
    end

    // datapath and held outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx        <= '0;
            ld_r       <= '0;
            ul_r       <= '0;
            nxt_r      <= '0;
            ent_base   <= '0;
            express_r  <= 1'b0;
            lat_queue  <= '0;
            lat_esize  <= '0;
            lat_depth  <= '0;
            lat_base   <= '0;
            ent_valid  <= 1'b0;
            empty      <= 1'b0;
            ptr_load   <= '0;
            ptr_unload <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (cmd_valid) begin
                    lat_queue <= cmd_queue;
                    lat_esize <= cmd_esize;
                    lat_depth <= cmd_depth;
                    lat_base  <= cmd_base;
                    express_r <= cmd_express;
                    ent_base  <= cmd_base;
                    idx       <= '0;
                    ent_valid <= 1'b0;
                    empty     <= 1'b0;
                end
                ST_HDR: if (mem_ack) begin
                    unique case (idx[1:0])
                        2'd0: ld_r[7:0]  <= mem_rdata;
                        2'd1: ld_r[15:8] <= mem_rdata;
                        2'd2: ul_r[7:0]  <= mem_rdata;
                        default: ul_r[15:8] <= mem_rdata;
                    endcase
                    idx <= (idx == 5'd3) ? 5'd0 : idx + 5'd1;
                end
                ST_TEST: begin
                    ent_base   <= hdr_addr + AW'(HDR_SIZE) + AW'(ul_r);
                    nxt_r      <= NXT_W'(ul_r) + NXT_W'(lat_esize);
                    ptr_load   <= ld_r;
                    ptr_unload <= ul_r;
                    idx        <= '0;
                end
                ST_ENT: if (mem_ack)
                    idx <= (idx == last_idx) ? 5'd0 : idx + 5'd1;
                ST_WRAP: if (wrap_ge) nxt_r <= wrap_red;
                ST_WB: if (mem_ack) begin
                    idx <= idx + 5'd1;
                    if (idx == 5'd1) ptr_unload <= nxt_r[PTR_W-1:0];
                end
                default: ;
            endcase
            if (nstate == ST_DONE && state != ST_DONE) begin
                if (state == ST_TEST) empty     <= 1'b1;
                else                  ent_valid <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ring_req_reader.sv
module ring_req_reader #(
    parameter int AW = 32,
    parameter int QW = 4,
    parameter int DW = 8,
    parameter int EW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic          cmd_express,
    input  logic [QW-1:0] cmd_queue,
    input  logic [EW-1:0] cmd_esize,
    input  logic [DW-1:0] cmd_depth,
    input  logic [AW-1:0] cmd_base,
    output logic          busy,
    output logic          done,
    output logic          ent_valid,
    output logic          empty,
    output logic [15:0]   ent_count,
    output logic [7:0]    ent_subdev,
    output logic [7:0]    ent_opcode,
    output logic [31:0]   ent_addr,
    output logic [63:0]   ent_app,
    output logic [15:0]   ptr_load,
    output logic [15:0]   ptr_unload,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic          mem_ack,
    input  logic [7:0]    mem_rdata
);
    localparam int SPAN_W = EW + DW;
    localparam int NXT_W  = ring_rd_pkg::NXT_W;

    logic [QW-1:0]     lat_queue;
    logic [EW-1:0]     lat_esize;
    logic [DW-1:0]     lat_depth;
    logic [AW-1:0]     lat_base;
    logic [AW-1:0]     hdr_addr;
    logic [SPAN_W-1:0] span;
    logic [NXT_W-1:0]  wrap_cur, wrap_red;
    logic              wrap_ge;
    logic              ent_clr, ent_cap;
    logic [3:0]        ent_idx;

    ring_addr_calc #(.AW(AW), .QW(QW), .DW(DW), .EW(EW)) u_addr (
        .base(lat_base), .queue(lat_queue), .esize(lat_esize), .depth(lat_depth),
        .hdr_addr(hdr_addr), .span(span)
    );

    ring_wrap_step #(.SPAN_W(SPAN_W), .NW(NXT_W)) u_wrap (
        .cur(wrap_cur), .span(span), .ge(wrap_ge), .reduced(wrap_red)
    );

    ring_seq_fsm #(.AW(AW), .QW(QW), .DW(DW), .EW(EW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_express(cmd_express), .cmd_queue(cmd_queue),
        .cmd_esize(cmd_esize), .cmd_depth(cmd_depth), .cmd_base(cmd_base),
        .lat_queue(lat_queue), .lat_esize(lat_esize), .lat_depth(lat_depth),
        .lat_base(lat_base), .hdr_addr(hdr_addr), .span(span),
        .wrap_cur(wrap_cur), .wrap_ge(wrap_ge), .wrap_red(wrap_red),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .ent_clr(ent_clr), .ent_cap(ent_cap), .ent_idx(ent_idx),
        .busy(busy), .done(done), .ent_valid(ent_valid), .empty(empty),
        .ptr_load(ptr_load), .ptr_unload(ptr_unload)
    );

    ring_entry_store u_store (
        .clk(clk), .rst_n(rst_n), .clr(ent_clr), .cap(ent_cap),
        .cap_idx(ent_idx), .cap_byte(mem_rdata),
        .ent_count(ent_count), .ent_subdev(ent_subdev), .ent_opcode(ent_opcode),
        .ent_addr(ent_addr), .ent_app(ent_app)
    );
endmodule

// File: rtl/ring_req_reader_chk.sv
module ring_req_reader_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic          busy,
    input logic          done,
    input logic          ent_valid,
    input logic          empty,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [7:0]    mem_wdata,
    input logic          mem_ack
);
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ent_valid ^ empty));

    a_r8_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cmd_valid) |=> ($stable(ent_valid) && $stable(empty)));

    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && (!mem_we || $stable(mem_wdata))));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    a_r3_no_write_after_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (!empty && !ent_valid));
endmodule

bind ring_req_reader ring_req_reader_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy), .done(done),
    .ent_valid(ent_valid), .empty(empty), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/ring_req_reader_test.sv
module ring_req_reader_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_express = 1'b0;
    logic [3:0]  cmd_queue = '0;
    logic [4:0]  cmd_esize = 5'd8;
    logic [7:0]  cmd_depth = '0;
    logic [31:0] cmd_base = '0;
    logic        busy, done, ent_valid, empty;
    logic [15:0] ent_count, ptr_load, ptr_unload;
    logic [7:0]  ent_subdev, ent_opcode, mem_wdata;
    logic [31:0] ent_addr, mem_addr;
    logic [63:0] ent_app;
    logic        mem_req, mem_we;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_rdata = '0;

    logic [7:0]  mem [0:65535];
    int          stall = 0, stall_cnt = 0;
    int          rd_cnt = 0, wr_cnt = 0, done_cnt = 0;
    logic        log_clr = 1'b0;
    int          lidx = 0;
    logic [15:0] alog [0:31];
    int          n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ring_req_reader uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_express(cmd_express),
        .cmd_queue(cmd_queue), .cmd_esize(cmd_esize), .cmd_depth(cmd_depth),
        .cmd_base(cmd_base), .busy(busy), .done(done), .ent_valid(ent_valid),
        .empty(empty), .ent_count(ent_count), .ent_subdev(ent_subdev),
        .ent_opcode(ent_opcode), .ent_addr(ent_addr), .ent_app(ent_app),
        .ptr_load(ptr_load), .ptr_unload(ptr_unload), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // byte memory with a programmable number of wait cycles
    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (done) done_cnt <= done_cnt + 1;
        if (log_clr) lidx <= 0;
        else if (mem_req && !mem_ack) begin
            if (stall_cnt < stall) stall_cnt <= stall_cnt + 1;
            else begin
                stall_cnt <= 0;
                mem_ack   <= 1'b1;
                mem_rdata <= mem[mem_addr[15:0]];
                if (lidx < 32) alog[lidx] <= mem_addr[15:0];
                lidx <= lidx + 1;
                if (mem_we) begin
                    mem[mem_addr[15:0]] <= mem_wdata;
                    wr_cnt <= wr_cnt + 1;
                end else rd_cnt <= rd_cnt + 1;
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] rd16(input int a);
        return {mem[(a + 1) & 16'hffff], mem[a & 16'hffff]};
    endfunction

    task automatic issue(input logic exp_sel, input int q, input int es, input int d, input int base);
        @(negedge clk);
        log_clr = 1'b1;
        @(negedge clk);
        log_clr     = 1'b0;
        cmd_valid   = 1'b1;
        cmd_express = exp_sel;
        cmd_queue   = 4'(q);
        cmd_esize   = 5'(es);
        cmd_depth   = 8'(d);
        cmd_base    = 32'(base);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        if (!done) chk({tag, " watchdog"}, 64'd0, 64'd1);
    endtask

    task automatic check_entry(input string tag, input int e, input int es);
        logic [63:0] app = '0;
        for (int k = 0; k < 8; k++)
            if (k < es - 8) app[8*k +: 8] = mem[(e + 8 + k) & 16'hffff];
        chk({tag, " R4 count"},  64'(ent_count),  64'(rd16(e)));
        chk({tag, " R4 subdev"}, 64'(ent_subdev), 64'(mem[(e + 2) & 16'hffff]));
        chk({tag, " R4 opcode"}, 64'(ent_opcode), 64'(mem[(e + 3) & 16'hffff]));
        chk({tag, " R4 addr"},   64'(ent_addr),   64'({rd16(e + 6), rd16(e + 4)}));
        chk({tag, " R4 app"},    ent_app, app);
    endtask

    task automatic run_queue(input int q, input int es, input int d, input int base,
                             input int ld, input int ul);
        int hdr, e, rd0, wr0, nu;
        hdr = base + es + q * (4 + es * d);
        mem[hdr & 16'hffff]       = 8'(ld);
        mem[(hdr + 1) & 16'hffff] = 8'(ld >> 8);
        mem[(hdr + 2) & 16'hffff] = 8'(ul);
        mem[(hdr + 3) & 16'hffff] = 8'(ul >> 8);
        e   = hdr + 4 + ul;
        rd0 = rd_cnt;
        wr0 = wr_cnt;
        issue(1'b0, q, es, d, base);
        wait_done("queue");
        chk("R8 done pulse", 64'(done), 64'd1);
        chk("R1 header address", 64'(alog[0]), 64'(hdr & 16'hffff));
        chk("R2 load pointer", 64'(ptr_load), 64'(ld));
        if (ld == ul) begin
            chk("R3 empty flag", 64'(empty), 64'd1);
            chk("R3 no entry", 64'(ent_valid), 64'd0);
            chk("R3 reads", 64'(rd_cnt - rd0), 64'd4);
            chk("R3 writes", 64'(wr_cnt - wr0), 64'd0);
            chk("R2 unload unchanged", 64'(ptr_unload), 64'(ul));
        end else begin
            chk("R4 valid", 64'({ent_valid, empty}), 64'b10);
            chk("R4 entry address", 64'(alog[4]), 64'(e & 16'hffff));
            chk("R4 reads", 64'(rd_cnt - rd0), 64'(4 + es));
            check_entry("queue", e, es);
            if (d != 0) begin
                nu = (ul + es) % (es * d);
                chk("R5 writes", 64'(wr_cnt - wr0), 64'd2);
                chk("R5 memory pointer", 64'(rd16(hdr + 2)), 64'(nu));
                chk("R2 unload output", 64'(ptr_unload), 64'(nu));
            end else begin
                chk("R6 no write", 64'(wr_cnt - wr0), 64'd0);
                chk("R6 pointer kept", 64'(ptr_unload), 64'(ul));
            end
        end
        @(negedge clk);
    endtask

    task automatic run_express(input int es, input int base);
        int rd0, wr0;
        rd0 = rd_cnt;
        wr0 = wr_cnt;
        issue(1'b1, 3, es, 2, base);
        wait_done("express");
        chk("R7 first read", 64'(alog[0]), 64'(base & 16'hffff));
        chk("R7 outcome", 64'({ent_valid, empty}), 64'b10);
        chk("R7 reads", 64'(rd_cnt - rd0), 64'(es));
        chk("R7 writes", 64'(wr_cnt - wr0), 64'd0);
        check_entry("express", base, es);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 65536; i++) mem[i] = 8'((i * 37) ^ (i >> 8) ^ 8'h5a);
        repeat (3) @(negedge clk);
        chk("R8 reset flags", 64'({busy, done, ent_valid, empty}), 64'd0);
        chk("R10 reset request", 64'(mem_req), 64'd0);
        rst_n = 1'b1;

        // sweep queue, entry size, depth and pointer position
        for (int q = 0; q < 4; q++)
            for (int es = 8; es <= 16; es++)
                for (int d = 0; d < 4; d++)
                    for (int k = 0; k < 3; k++) begin
                        int ul, ld;
                        stall = (q + es + k) % 3;
                        ul = (k == 0) ? 0 : es * ((d > 1) ? d - 1 : 1);
                        ld = (k == 2) ? ul : ul + es;
                        run_queue(q, es, d, 16'h0100 + es * 3, ld, ul);
                    end

        // exact modulo of a pointer far outside its ring (R5)
        stall = 0;
        run_queue(1, 8, 3, 16'h0080, 0, 60000);

        // express slot across all sizes (R7)
        for (int es = 8; es <= 16; es++) begin
            stall = es % 2;
            run_express(es, 16'h0400 + es * 5);
        end

        // command while busy is ignored (R9)
        begin
            int hdr, d0;
            stall = 2;
            hdr = 16'h0300 + 12 + 2 * (4 + 12 * 2);
            mem[hdr] = 8'd12; mem[hdr + 1] = 8'd0;
            mem[hdr + 2] = 8'd0; mem[hdr + 3] = 8'd0;
            issue(1'b0, 2, 12, 2, 16'h0300);
            @(negedge clk);
            chk("R9 busy", 64'(busy), 64'd1);
            cmd_valid = 1'b1; cmd_express = 1'b1; cmd_base = 32'h0500;
            @(negedge clk);
            cmd_valid = 1'b0;
            wait_done("busy");
            d0 = done_cnt;
            chk("R9 first command kept", 64'(alog[0]), 64'(hdr));
            chk("R9 pointer advanced", 64'(ptr_unload), 64'd12);
            repeat (20) @(negedge clk);
            chk("R9 no extra done", 64'(done_cnt - d0), 64'd1);
            chk("R8 flags held idle", 64'({ent_valid, empty}), 64'b10);
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule